// File: doc/BRIEF.md
# Framed Serial Byte Transmitter

This block takes bytes written over a simple push port and queues them in a small FIFO. It then sends each byte out as one serial frame toward an audio codec. A frame is eight bit periods long, with the most significant bit first. A frame sync output marks the first bit period of every frame. The block does not generate the bit clock. A separate divider delivers a one-cycle strobe for each rising edge of the bit clock, and every state change in the serializer happens on one of those strobes.

While transmission is enabled and the divisor input is non-zero, frames follow each other with no gap. If the queue is empty when a frame is due, a filler byte of 0x00 goes out in its place. When the enable is cleared, the block keeps going until it has sent every queued byte, and only then returns to idle. A busy flag, empty and full flags and an active-high request output tell the host when to refill the queue. The request is raised while fewer than half of the FIFO entries are occupied.

The serializer is a three-state machine:
- IDLE: nothing in flight.
- SEND: a frame is in flight while enabled.
- DRAIN: a frame is in flight after the enable was cleared.

Its named transitions are:
- start (IDLE to SEND)
- refill (SEND or DRAIN to SEND)
- flush (SEND or DRAIN to DRAIN)
- stop (SEND or DRAIN to IDLE)

All transitions happen only at a frame boundary, which is a strobe that arrives while idle or right after bit 0.

Top module: `ser_byte_tx`

## Requirements
- R1: Each frame carries 8 bits, most significant first, and advances one bit per `bit_rise` strobe. `sdata` shows the new bit from the clock cycle after the strobe and holds it between strobes.
- R2: `fsync` is high for exactly the first bit period of each frame, together with bit 7. Both `fsync` and `sdata` are low while the block is idle.
- R3: While enabled, the strobe after bit 0 starts the next frame at once (back to back). This is the refill transition.
- R4: If the FIFO is empty at a frame start while enabled, the byte 0x00 is sent. Filler frames continue until a byte is queued, and that byte is sent in the next frame.
- R5: A frame starts from IDLE only when `tx_en` is 1 and `clk_div` is non-zero. Otherwise strobes start nothing and the queued bytes stay in the FIFO.
- R6: After `tx_en` is cleared, every queued byte is still sent in order (flush). The strobe after the last bit 0 returns the block to IDLE (stop).
- R7: `busy` is high while a frame is in flight or the FIFO holds at least one byte, and low otherwise.
- R8: `tx_irq` is high exactly while FIFO occupancy is below DEPTH/2, which is 8 for the default depth of 16.
- R9: A write while the FIFO is full is discarded. The stored bytes are still sent unchanged and in order.
- R10: After reset, `q_empty`=1, `q_full`=0, `busy`=0, `tx_irq`=1 and the outputs are low. The empty and full flags reflect the occupancy from the cycle after each push or pop.
- R11: A push in the same cycle as the pop of a frame start both take effect. The popped byte is sent now and the pushed byte is kept for a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Push strobe for the transmit FIFO |
| wr_data | input | 8 | Byte to push |
| tx_en | input | 1 | Transmit enable |
| clk_div | input | 10 | Bit clock divisor setting; zero inhibits transmit |
| bit_rise | input | 1 | One-cycle strobe per bit clock rising edge |
| sdata | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync, high during the first bit |
| q_empty | output | 1 | FIFO empty |
| q_full | output | 1 | FIFO full |
| busy | output | 1 | Data queued or in flight |
| tx_irq | output | 1 | FIFO occupancy below half depth |

## Verification
Two functions can fall in the same clock cycle: a host push and the FIFO pop that loads the shift register at a frame boundary. The bench provokes this with one byte queued and the block enabled. It raises `wr_en` in the very cycle the `bit_rise` strobe starts a frame. The result is judged in two ways. First, `q_empty` must stay low right after that cycle. Second, the serial output must carry the older byte in that frame and the newly pushed byte in the frame after it.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_DRAIN = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sbt_fifo.sv
`timescale 1ns/1ps
module sbt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [W-1:0]    slot_q [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic [CNTW-1:0] cnt_q;
    logic            do_push, do_pop;

    assign do_push = push && (cnt_q != FULL_CNT);
    assign do_pop  = pop  && (cnt_q != '0);

    // one register per entry, written only when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wptr_q == AW'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + AW'(1);
            if (do_pop)  rptr_q <= rptr_q + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = slot_q[rptr_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == FULL_CNT);
endmodule

// File: rtl/sbt_frame_fsm.sv
`timescale 1ns/1ps
module sbt_frame_fsm
    import sbt_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] FILL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_rise,
    input  logic         run_ok,
    input  logic         q_empty,
    input  logic [W-1:0] q_rdata,
    output logic         q_pop,
    output logic         sdata,
    output logic         fsync,
    output logic         active
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] TOP = CW'(W - 1);

    tx_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [W-1:0]  sh_q, sh_d;
    logic          boundary;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    // next state: transitions only at a frame boundary
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        sh_d     = sh_q;
        q_pop    = 1'b0;
        boundary = bit_rise && ((st_q == ST_IDLE) || (cnt_q == '0));
        unique case (st_q)
            ST_IDLE: begin
                if (boundary && run_ok) begin          // start
                    st_d  = ST_SEND;
                    cnt_d = TOP;
                    sh_d  = q_empty ? FILL : q_rdata;
                    q_pop = !q_empty;
                end
            end
            ST_SEND, ST_DRAIN: begin
                if (boundary) begin
                    if (run_ok) begin                  // refill
                        st_d  = ST_SEND;
                        cnt_d = TOP;
                        sh_d  = q_empty ? FILL : q_rdata;
                        q_pop = !q_empty;
                    end else if (!q_empty) begin       // flush
                        st_d  = ST_DRAIN;
                        cnt_d = TOP;
                        sh_d  = q_rdata;
                        q_pop = 1'b1;
                    end else begin                     // stop
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                        sh_d  = '0;
                    end
                end else if (bit_rise) begin
                    cnt_d = cnt_q - CW'(1);
                    sh_d  = {sh_q[W-2:0], 1'b0};
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        active = (st_q != ST_IDLE);
        sdata  = active && sh_q[W-1];
        fsync  = active && (cnt_q == TOP);
    end
endmodule

// File: rtl/sbt_status.sv
`timescale 1ns/1ps
module sbt_status #(
    parameter int DEPTH = 16
) (
    input  logic                   active,
    input  logic [$clog2(DEPTH):0] count,
    output logic                   busy,
    output logic                   tx_irq
);
    localparam int CNTW = $clog2(DEPTH) + 1;
    localparam logic [CNTW-1:0] HALF = CNTW'(DEPTH / 2);

    assign busy   = active || (count != '0);
    assign tx_irq = (count < HALF);
endmodule

// File: rtl/ser_byte_tx.sv
`timescale 1ns/1ps
module ser_byte_tx #(
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 16,
    parameter int                DIV_W     = 10,
    parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              bit_rise,
    output logic              sdata,
    output logic              fsync,
    output logic              q_empty,
    output logic              q_full,
    output logic              busy,
    output logic              tx_irq
);
    localparam int CNTW = $clog2(DEPTH) + 1;

    logic [DATA_W-1:0] q_rdata;
    logic [CNTW-1:0]   q_count;
    logic              q_pop, active, run_ok;

    assign run_ok = tx_en && (clk_div != '0);

    sbt_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .wdata (wr_data),
        .pop   (q_pop),
        .rdata (q_rdata),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    sbt_frame_fsm #(.W(DATA_W), .FILL(FILL_BYTE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .run_ok   (run_ok),
        .q_empty  (q_empty),
        .q_rdata  (q_rdata),
        .q_pop    (q_pop),
        .sdata    (sdata),
        .fsync    (fsync),
        .active   (active)
    );

    sbt_status #(.DEPTH(DEPTH)) u_status (
        .active (active),
        .count  (q_count),
        .busy   (busy),
        .tx_irq (tx_irq)
    );
endmodule

// File: rtl/sbt_checker.sv
`timescale 1ns/1ps
module sbt_checker #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tx_en,
    input logic [DIV_W-1:0] clk_div,
    input logic             bit_rise,
    input logic             sdata,
    input logic             fsync,
    input logic             q_empty,
    input logic             q_full,
    input logic             busy,
    input logic             tx_irq
);
    assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> ($stable(sdata) && $stable(fsync)));

    assert_sync_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && bit_rise) |=> !fsync);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fsync && !sdata));

    assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(tx_en && (clk_div != '0))) |=> !fsync);

    assert_queue_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !q_empty |-> busy);

    assert_irq_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !tx_irq);

    assert_irq_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> tx_irq);

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && wr_en && !bit_rise) |=> q_full);

    assert_push_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && wr_en) |=> !q_empty);
endmodule

bind ser_byte_tx sbt_checker #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .tx_en    (tx_en),
    .clk_div  (clk_div),
    .bit_rise (bit_rise),
    .sdata    (sdata),
    .fsync    (fsync),
    .q_empty  (q_empty),
    .q_full   (q_full),
    .busy     (busy),
    .tx_irq   (tx_irq)
);

// File: tb/tb_ser_byte_tx.sv
`timescale 1ns/1ps
module tb_ser_byte_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_en = 1'b0;
    logic [9:0] clk_div = '0;
    logic       bit_rise = 1'b0;
    logic       sdata, fsync, q_empty, q_full, busy, tx_irq;

    int total = 0;
    int bad = 0;
    logic s_data, s_sync, s_busy;

    always #2.5 clk = ~clk;

    ser_byte_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_en(tx_en), .clk_div(clk_div), .bit_rise(bit_rise),
        .sdata(sdata), .fsync(fsync), .q_empty(q_empty), .q_full(q_full),
        .busy(busy), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit clock rising edge strobe, sampled after the register update
    task automatic tick();
        @(negedge clk) bit_rise = 1'b1;
        @(negedge clk) bit_rise = 1'b0;
        s_data = sdata;
        s_sync = fsync;
        s_busy = busy;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic expect_frame(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            tick();
            chk(req, s_data, b[i]);
            chk(req, s_sync, (i == 7));
        end
    endtask

    task automatic settle();
        int k = 0;
        tx_en = 1'b0;
        while (busy && k < 40) begin
            tick();
            k++;
        end
    endtask

    task automatic t_reset();
        chk("R10 empty", q_empty, 1);
        chk("R10 full", q_full, 0);
        chk("R10 busy", busy, 0);
        chk("R10 irq", tx_irq, 1);
        chk("R2 idle sdata", sdata, 0);
        chk("R2 idle fsync", fsync, 0);
    endtask

    task automatic t_basic_and_filler();
        clk_div = 10'd287;
        push(8'hA5);
        chk("R10 empty after push", q_empty, 0);
        tx_en = 1'b1;
        expect_frame(8'hA5, "R1");
        expect_frame(8'h00, "R4");
        chk("R7 busy filler", busy, 1);
        expect_frame(8'h00, "R4");
        push(8'h5A);
        expect_frame(8'h5A, "R4");
        settle();
        chk("R7 idle busy", busy, 0);
    endtask

    task automatic t_back_to_back();
        push(8'h3C);
        push(8'hC3);
        tx_en = 1'b1;
        expect_frame(8'h3C, "R3");
        expect_frame(8'hC3, "R3");
        settle();
    endtask

    task automatic t_inhibit();
        clk_div = '0;
        tx_en = 1'b1;
        push(8'h77);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R5 no sync", s_sync, 0);
        end
        chk("R5 kept", q_empty, 0);
        chk("R7 queued busy", busy, 1);
        clk_div = 10'd5;
        tx_en = 1'b0;
        tick();
        chk("R5 disabled", s_sync, 0);
        tx_en = 1'b1;
        expect_frame(8'h77, "R5");
        settle();
    endtask

    task automatic t_drain();
        push(8'h11);
        push(8'h22);
        push(8'h33);
        tx_en = 1'b1;
        expect_frame(8'h11, "R6");
        tx_en = 1'b0;
        expect_frame(8'h22, "R6");
        expect_frame(8'h33, "R6");
        chk("R7 last bit busy", busy, 1);
        tick();
        chk("R6 stop", s_busy, 0);
        chk("R6 stop sync", s_sync, 0);
        tick();
        chk("R6 stays idle", s_sync, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) begin
            push(8'h40 + 8'(i));
            chk("R8 irq", tx_irq, ((i + 1) < 8) ? 1 : 0);
            if (i == 14) chk("R10 not full", q_full, 0);
        end
        chk("R10 full", q_full, 1);
        push(8'hEE);
        chk("R9 still full", q_full, 1);
        tx_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            expect_frame(8'h40 + 8'(i), "R9");
        end
        expect_frame(8'h00, "R9 discarded");
        settle();
    endtask

    task automatic t_collide();
        push(8'h6B);
        tx_en = 1'b1;
        @(negedge clk) begin bit_rise = 1'b1; wr_en = 1'b1; wr_data = 8'h9D; end
        @(negedge clk) begin bit_rise = 1'b0; wr_en = 1'b0; end
        chk("R11 sync", fsync, 1);
        chk("R11 bit7", sdata, 0);
        chk("R11 kept", q_empty, 0);
        @(negedge clk);
        for (int i = 6; i >= 0; i--) begin
            tick();
            chk("R11 bits", s_data, (8'h6B >> i) & 1);
        end
        expect_frame(8'h9D, "R11");
        settle();
        chk("R11 idle", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_and_filler();
        t_back_to_back();
        t_inhibit();
        t_drain();
        t_full();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule